// File: doc/BRIEF.md
# Utilization-Driven Datapath Half-Width Gating Controller

This controller decides, once per fixed observation window, which upper halves of a SIMT core's datapath can be switched off without hurting throughput. Each cycle it samples busy flags from the three execute lanes (simple ALU, special-function and load/store), from the three pipeline stages that feed each lane, from the issue scheduler and from fetch/decode. It also accumulates load/store arrivals and the number of memory requests in flight. When the window closes it runs three decision steps, one per cycle and always in the same order: execute units first, then the stages that feed them, then the scheduler and fetch/decode. It then publishes all the new gate controls together.

The decisions look for bottlenecks rather than for idle units. A feeding stage is gated only when it is less busy than the execute unit it serves. The scheduler is halved only when it is less busy than all three execute units together. Fetch/decode is halved only when it is less busy than the scheduler. The load/store half is clock-gated when the mean memory response time is long. That mean is estimated from the ratio of in-flight requests to arrivals, and a multiply-compare stands in for the division. Every control acts on the upper half of a component only, so the lower half always stays powered. Units that keep state (stage registers, register-file banks, the load/store queue) are given clock-gate controls. Only the two arithmetic execute units are given power-gate controls.

Top module: `dpath_gate_ctrl`

## Requirements
- R1: While `rst` is high, and from reset until the first `done` pulse, every gate output and `done` are 0, so the full width is on.
- R2: A counting window lasts `EPOCH_LEN` cycles and is followed by three decision cycles. `done` is high for exactly one cycle at the end of each sequence, so `done` pulses repeat every `EPOCH_LEN+3` cycles. Gate outputs change only in the cycle in which `done` is high.
- R3: `ex_pg[l]` (bit 0 = simple ALU lane, bit 1 = special-function lane) is 1 when that lane's execute busy count in the window is strictly below `EPOCH_LEN >> lowu_shift`.
- R4: `ls_cg` is 1 when the window saw at least one `ls_arrive` and the sum of `ls_outstanding` over the window is at least `lat_thresh` times the number of arrivals.
- R5: For each lane l (bit 0 = simple ALU, bit 1 = special-function, bit 2 = load/store), `idoc_cg[l]`, `oc_cg[l]` and `ocex_cg[l]` are 1 when that stage's busy count is strictly below the busy count of the same lane's execute unit.
- R6: `sch_half` is 1 when the scheduler busy count is strictly below the sum of the three execute-lane busy counts.
- R7: `ifid_half` is 1 when the fetch/decode busy count is strictly below the scheduler busy count.
- R8: Inputs applied during the three decision cycles are not counted, and every count starts from zero in each new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lowu_shift | input | SHIFT_W | Low-utilization limit as a right shift of the window length |
| lat_thresh | input | THR_W | Response-time threshold in cycles for load/store clock gating |
| ex_busy | input | 3 | Execute unit busy per lane |
| idoc_busy | input | 3 | Issue-to-collector register busy per lane |
| oc_busy | input | 3 | Operand collector / register-file bank busy per lane |
| ocex_busy | input | 3 | Collector-to-execute register busy per lane |
| sch_busy | input | 1 | Scheduler issued this cycle |
| ifid_busy | input | 1 | Fetch/decode active this cycle |
| ls_arrive | input | 1 | A load/store request entered the unit |
| ls_outstanding | input | OUTS_W | Load/store requests currently in flight |
| ex_pg | output | 2 | Power-gate upper half of ALU / special-function execute units |
| ls_cg | output | 1 | Clock-gate upper half of the load/store unit |
| idoc_cg | output | 3 | Clock-gate upper half of issue-to-collector registers per lane |
| oc_cg | output | 3 | Clock-gate upper half of collector / register-file banks per lane |
| ocex_cg | output | 3 | Clock-gate upper half of collector-to-execute registers per lane |
| sch_half | output | 1 | Halve the issue width |
| ifid_half | output | 1 | Halve the fetch/decode width |
| done | output | 1 | One-cycle pulse when new decisions are published |

## Verification
The bench builds the block with a 16-cycle window, a 4-bit in-flight count, a 3-bit latency threshold and a 3-bit shift. With a window this short, every busy count from 0 to 16 can be reached in a single window. Each shift from 0 to 4 is tried, which takes the low-utilization limit from 16 down to 1, and the latency threshold is swept over all eight values. Directed windows land exactly on the equality boundaries (count equal to the limit, stage equal to its execute unit, accumulated in-flight count equal to threshold times arrivals), and every decision cycle is filled with busy activity to show that none of it is counted.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
    localparam int NLANE  = 3;
    localparam int NARITH = 2;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_PH1   = 2'd1,
        ST_PH2   = 2'd2,
        ST_PH3   = 2'd3
    } phase_e;
endpackage

// File: rtl/dgc_busy_ctr.sv
module dgc_busy_ctr #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             busy,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en && busy)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dgc_lat_est.sv
module dgc_lat_est #(
    parameter int CNT_W  = 13,
    parameter int OUTS_W = 8,
    parameter int THR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              arrive,
    input  logic [OUTS_W-1:0] outstanding,
    input  logic [THR_W-1:0]  thresh,
    output logic              lat_hi
);
    localparam int ACC_W  = CNT_W + OUTS_W;
    localparam int PROD_W = CNT_W + THR_W;
    localparam int CMP_W  = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] arr;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.acc = '0;
            s_d.arr = '0;
        end else if (en) begin
            s_d.acc = s_q.acc + ACC_W'(outstanding);
            if (arrive) s_d.arr = s_q.arr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // Little's Law without division: mean response = acc / arr >= thresh
    logic [CMP_W-1:0] limit;
    assign limit  = CMP_W'(s_q.arr) * CMP_W'(thresh);
    assign lat_hi = (s_q.arr != '0) && (CMP_W'(s_q.acc) >= limit);
endmodule

// File: rtl/dpath_gate_ctrl.sv
module dpath_gate_ctrl
    import dgc_pkg::*;
#(
    parameter int EPOCH_LEN = 4096,
    parameter int OUTS_W    = 8,
    parameter int THR_W     = 4,
    parameter int SHIFT_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SHIFT_W-1:0] lowu_shift,
    input  logic [THR_W-1:0]   lat_thresh,
    input  logic [2:0]         ex_busy,
    input  logic [2:0]         idoc_busy,
    input  logic [2:0]         oc_busy,
    input  logic [2:0]         ocex_busy,
    input  logic               sch_busy,
    input  logic               ifid_busy,
    input  logic               ls_arrive,
    input  logic [OUTS_W-1:0]  ls_outstanding,
    output logic [1:0]         ex_pg,
    output logic               ls_cg,
    output logic [2:0]         idoc_cg,
    output logic [2:0]         oc_cg,
    output logic [2:0]         ocex_cg,
    output logic               sch_half,
    output logic               ifid_half,
    output logic               done
);
    localparam int CNT_W = $clog2(EPOCH_LEN + 1);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [CNT_W-1:0] EPOCH_V   = CNT_W'(EPOCH_LEN);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(EPOCH_LEN - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   tick;
        logic [NARITH-1:0]  pg_p;
        logic               ls_p;
        logic [NLANE-1:0]   idoc_p;
        logic [NLANE-1:0]   oc_p;
        logic [NLANE-1:0]   ocex_p;
        logic [NARITH-1:0]  pg;
        logic               ls;
        logic [NLANE-1:0]   idoc;
        logic [NLANE-1:0]   oc;
        logic [NLANE-1:0]   ocex;
        logic               sch;
        logic               ifid;
        logic               done;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic cnt_en, cnt_clr, lat_hi;
    logic [CNT_W-1:0] ex_cnt   [NLANE];
    logic [CNT_W-1:0] idoc_cnt [NLANE];
    logic [CNT_W-1:0] oc_cnt   [NLANE];
    logic [CNT_W-1:0] ocex_cnt [NLANE];
    logic [CNT_W-1:0] sch_cnt, ifid_cnt;
    logic [CNT_W-1:0] lowu_lim;
    logic [SUM_W-1:0] ex_sum;

    assign cnt_en  = (s_q.ph == ST_COUNT);
    assign cnt_clr = (s_q.ph == ST_PH3);

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        dgc_busy_ctr #(.CNT_W(CNT_W)) u_ex (
            .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
            .busy(ex_busy[l]), .cnt(ex_cnt[l]));
        dgc_busy_ctr #(.CNT_W(CNT_W)) u_idoc (
            .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
            .busy(idoc_busy[l]), .cnt(idoc_cnt[l]));
        dgc_busy_ctr #(.CNT_W(CNT_W)) u_oc (
            .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
            .busy(oc_busy[l]), .cnt(oc_cnt[l]));
        dgc_busy_ctr #(.CNT_W(CNT_W)) u_ocex (
            .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
            .busy(ocex_busy[l]), .cnt(ocex_cnt[l]));
    end

    dgc_busy_ctr #(.CNT_W(CNT_W)) u_sch (
        .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
        .busy(sch_busy), .cnt(sch_cnt));
    dgc_busy_ctr #(.CNT_W(CNT_W)) u_ifid (
        .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
        .busy(ifid_busy), .cnt(ifid_cnt));

    dgc_lat_est #(.CNT_W(CNT_W), .OUTS_W(OUTS_W), .THR_W(THR_W)) u_lat (
        .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
        .arrive(ls_arrive), .outstanding(ls_outstanding),
        .thresh(lat_thresh), .lat_hi(lat_hi));

    assign lowu_lim = EPOCH_V >> lowu_shift;
    assign ex_sum   = SUM_W'(ex_cnt[0]) + SUM_W'(ex_cnt[1]) + SUM_W'(ex_cnt[2]);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            ST_COUNT: begin
                if (s_q.tick == LAST_TICK) begin
                    s_d.tick = '0;
                    s_d.ph   = ST_PH1;
                end else begin
                    s_d.tick = s_q.tick + 1'b1;
                end
            end
            ST_PH1: begin
                // execute units: power-gate idle arithmetic halves, clock-gate slow load/store
                for (int l = 0; l < NARITH; l++)
                    s_d.pg_p[l] = (ex_cnt[l] < lowu_lim);
                s_d.ls_p = lat_hi;
                s_d.ph   = ST_PH2;
            end
            ST_PH2: begin
                // feeding stages versus their own execute unit
                for (int l = 0; l < NLANE; l++) begin
                    s_d.idoc_p[l] = (idoc_cnt[l] < ex_cnt[l]);
                    s_d.oc_p[l]   = (oc_cnt[l]   < ex_cnt[l]);
                    s_d.ocex_p[l] = (ocex_cnt[l] < ex_cnt[l]);
                end
                s_d.ph = ST_PH3;
            end
            ST_PH3: begin
                s_d.pg   = s_q.pg_p;
                s_d.ls   = s_q.ls_p;
                s_d.idoc = s_q.idoc_p;
                s_d.oc   = s_q.oc_p;
                s_d.ocex = s_q.ocex_p;
                s_d.sch  = (SUM_W'(sch_cnt) < ex_sum);
                s_d.ifid = (ifid_cnt < sch_cnt);
                s_d.done = 1'b1;
                s_d.ph   = ST_COUNT;
            end
            default: s_d.ph = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ex_pg     = s_q.pg;
    assign ls_cg     = s_q.ls;
    assign idoc_cg   = s_q.idoc;
    assign oc_cg     = s_q.oc;
    assign ocex_cg   = s_q.ocex;
    assign sch_half  = s_q.sch;
    assign ifid_half = s_q.ifid;
    assign done      = s_q.done;
endmodule

// File: rtl/dgc_checker.sv
module dgc_checker #(
    parameter int EPOCH_LEN = 4096
) (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic [13:0] gates
);
    localparam int GAP_W = $clog2(EPOCH_LEN + 4) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            gap_q <= done ? GAP_W'(1) : gap_q + 1'b1;
            if (done) seen_q <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gates == '0 && !done));

    assert_first_epoch_off_R1: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && !done) |-> (gates == '0));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_epoch_period_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (gap_q == GAP_W'(EPOCH_LEN + 3)));

    assert_gates_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(gates) |-> done);
endmodule

bind dpath_gate_ctrl dgc_checker #(.EPOCH_LEN(EPOCH_LEN)) u_chk (
    .clk(clk), .rst(rst), .done(done),
    .gates({ex_pg, ls_cg, idoc_cg, oc_cg, ocex_cg, sch_half, ifid_half}));

// File: tb/dpath_gate_ctrl_test.sv
module dpath_gate_ctrl_test;
    localparam int EP = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] lowu_shift;
    logic [2:0] lat_thresh;
    logic [2:0] ex_busy, idoc_busy, oc_busy, ocex_busy;
    logic       sch_busy, ifid_busy, ls_arrive;
    logic [3:0] ls_outstanding;
    logic [1:0] ex_pg;
    logic       ls_cg;
    logic [2:0] idoc_cg, oc_cg, ocex_cg;
    logic       sch_half, ifid_half, done;

    always #5 clk = ~clk;

    dpath_gate_ctrl #(.EPOCH_LEN(EP), .OUTS_W(4), .THR_W(3), .SHIFT_W(3)) uut (
        .clk(clk), .rst(rst), .lowu_shift(lowu_shift), .lat_thresh(lat_thresh),
        .ex_busy(ex_busy), .idoc_busy(idoc_busy), .oc_busy(oc_busy),
        .ocex_busy(ocex_busy), .sch_busy(sch_busy), .ifid_busy(ifid_busy),
        .ls_arrive(ls_arrive), .ls_outstanding(ls_outstanding),
        .ex_pg(ex_pg), .ls_cg(ls_cg), .idoc_cg(idoc_cg), .oc_cg(oc_cg),
        .ocex_cg(ocex_cg), .sch_half(sch_half), .ifid_half(ifid_half), .done(done));

    int errors = 0;
    int checks = 0;
    int ex_n[3], idoc_n[3], oc_n[3], ocex_n[3];
    int sch_n, ifid_n, arr_n, outs_v, shift_v, th_v;
    logic [13:0] prev_g = '0;
    int unsigned seed = 32'h2468_ace1;

    function automatic int rnd(int m);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % 32'(m));
    endfunction

    function automatic logic [13:0] gates_now();
        return {ex_pg, ls_cg, idoc_cg, oc_cg, ocex_cg, sch_half, ifid_half};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(int c);
        for (int l = 0; l < 3; l++) begin
            ex_busy[l]   = (c < ex_n[l]);
            idoc_busy[l] = (c < idoc_n[l]);
            oc_busy[l]   = (c < oc_n[l]);
            ocex_busy[l] = (c < ocex_n[l]);
        end
        sch_busy       = (c < sch_n);
        ifid_busy      = (c < ifid_n);
        ls_arrive      = (c < arr_n);
        ls_outstanding = 4'(outs_v);
    endtask

    task automatic noise();
        ex_busy = '1; idoc_busy = '1; oc_busy = '1; ocex_busy = '1;
        sch_busy = 1'b1; ifid_busy = 1'b1; ls_arrive = 1'b1; ls_outstanding = 4'hf;
    endtask

    task automatic run_epoch(bit first);
        int e_pg, e_ls, e_idoc, e_oc, e_ocex, e_sch, e_ifid;
        lowu_shift = 3'(shift_v);
        lat_thresh = 3'(th_v);
        for (int c = 0; c < EP; c++) begin
            drive(c);
            @(negedge clk);
            if (c == 0) begin
                check("R2 done low after pulse", int'(done), 0);
                if (first) check("R1 gates off in first epoch", int'(gates_now()), 0);
                else       check("R2 gates hold between pulses", int'(gates_now()), int'(prev_g));
            end
        end
        for (int d = 0; d < 3; d++) begin
            noise();   // R8: decision-cycle activity must not be counted
            @(negedge clk);
            if (d == 1) check("R2 no early done", int'(done), 0);
        end
        e_pg = 0; e_idoc = 0; e_oc = 0; e_ocex = 0;
        for (int l = 0; l < 2; l++) if (ex_n[l] < (EP >> shift_v)) e_pg += (1 << l);
        for (int l = 0; l < 3; l++) begin
            if (idoc_n[l] < ex_n[l]) e_idoc += (1 << l);
            if (oc_n[l]   < ex_n[l]) e_oc   += (1 << l);
            if (ocex_n[l] < ex_n[l]) e_ocex += (1 << l);
        end
        e_ls   = (arr_n > 0 && EP * outs_v >= th_v * arr_n) ? 1 : 0;
        e_sch  = (sch_n < ex_n[0] + ex_n[1] + ex_n[2]) ? 1 : 0;
        e_ifid = (ifid_n < sch_n) ? 1 : 0;
        check("R2 done pulse", int'(done), 1);
        check("R3 arith power gate", int'(ex_pg), e_pg);
        check("R4 load/store latency gate", int'(ls_cg), e_ls);
        check("R5 issue-collector gate", int'(idoc_cg), e_idoc);
        check("R5 collector gate", int'(oc_cg), e_oc);
        check("R5 collector-execute gate", int'(ocex_cg), e_ocex);
        check("R6 issue halving", int'(sch_half), e_sch);
        check("R7 fetch halving", int'(ifid_half), e_ifid);
        prev_g = gates_now();
    endtask

    task automatic set_rand(int e);
        for (int l = 0; l < 3; l++) begin
            ex_n[l]   = rnd(EP + 1);
            idoc_n[l] = (rnd(3) == 0) ? ex_n[l] : rnd(EP + 1);
            oc_n[l]   = (rnd(3) == 0) ? ex_n[l] : rnd(EP + 1);
            ocex_n[l] = rnd(EP + 1);
        end
        sch_n   = rnd(EP + 1);
        ifid_n  = (rnd(4) == 0) ? sch_n : rnd(EP + 1);
        arr_n   = rnd(EP + 1);
        outs_v  = rnd(16);
        shift_v = e % 5;
        th_v    = e % 8;
    endtask

    task automatic set_all(int v);
        for (int l = 0; l < 3; l++) begin
            ex_n[l] = v; idoc_n[l] = v; oc_n[l] = v; ocex_n[l] = v;
        end
        sch_n = v; ifid_n = v; arr_n = v; outs_v = 0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1;
        lowu_shift = '0;
        lat_thresh = '0;
        noise();
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R1 reset gates", int'(gates_now()), 0);
        check("R1 reset done", int'(done), 0);
        rst = 1'b0;

        // R1/R3: first epoch idle; decisions appear only at first pulse
        set_all(0); shift_v = 0; th_v = 1;
        run_epoch(1'b1);

        // R3 boundary: count equal to limit is not gated, one below is
        set_all(8); ex_n[0] = 7; shift_v = 1; th_v = 1;
        run_epoch(1'b0);

        // R4 boundary: 16*2 == 4*8 -> gated; then 16*1 < 4*8 -> not gated
        set_all(8); arr_n = 8; outs_v = 2; th_v = 4; shift_v = 2;
        run_epoch(1'b0);
        outs_v = 1;
        run_epoch(1'b0);

        // R5/R6/R7: stages one below their unit, scheduler at sum boundary
        set_all(5); idoc_n[2] = 4; oc_n[1] = 4; ocex_n[0] = 4;
        sch_n = 15; ifid_n = 14; arr_n = 0; outs_v = 15; th_v = 0;
        run_epoch(1'b0);
        sch_n = 14;
        run_epoch(1'b0);

        // R8: full counts followed by an empty window must not carry over
        set_all(EP); outs_v = 15; th_v = 7; shift_v = 0;
        run_epoch(1'b0);
        set_all(0); th_v = 0;
        run_epoch(1'b0);

        for (int e = 0; e < 60; e++) begin
            set_rand(e);
            run_epoch(1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule